// File: doc/BRIEF.md
# Migratory-Adaptive Snooping Coherence Controller

This block keeps the coherence state of a small array of cache lines for one processor's cache on a snooping bus. Beside the four usual invalidation states it tracks three more: a two-copy shared state, a migratory-clean state and a migratory-dirty state. Each line also stores the ID of the processor that last wrote it. From that ID and the two-copy state the block detects data that passes from one processor to the next. Once a line is seen as migratory, a plain bus read hands it over whole: the old holder invalidates its copy, and the new holder can then write without a second bus request.

Each cycle the block takes at most one processor access (read or write, with a line index) and at most one snooped bus transaction (read or read-exclusive, with a line index and the requester's ID). For a processor access it drives the bus request that is needed. It uses the shared and migratory response lines that the other caches return in the same cycle to pick the fill state. For a snoop it drives this cache's shared, migratory, data-supply and write-back responses. Data storage, replacement, arbitration and memory timing sit outside the block.

Top module: `mig_coh_ctrl`

## Requirements
- R1: After reset every line is Invalid. `line_state` shows the current state of line `proc_idx` with the encoding Invalid=0, Shared=1, Exclusive=2, Dirty=3, Shared-2=4, Migratory-Clean=5, Migratory-Dirty=6.
- R2: A read of an Invalid line raises `bus_req` with `bus_cmd`=0 (bus read). The line fills as Migratory-Clean if `resp_migr` is high, otherwise as Shared if `resp_shared` is high, otherwise as Exclusive. A read of a valid line raises no request and leaves the state as it is.
- R3: A write to Exclusive goes to Dirty and a write to Migratory-Clean goes to Migratory-Dirty. Dirty and Migratory-Dirty keep their state on a write. None of these writes raises a bus request.
- R4: A write to an Invalid line raises `bus_req` with `bus_cmd`=1 (read-exclusive), and the line becomes Dirty.
- R5: A write to a Shared line raises a read-exclusive request. The line becomes Migratory-Dirty if `resp_migr` is high in that cycle, otherwise Dirty.
- R6: A write to a Shared-2 line raises a read-exclusive request. The line becomes Migratory-Dirty if its stored last writer differs from `MY_ID`, otherwise Dirty. Every completed write stores `MY_ID` as the last writer, and a read fill stores `fill_writer`.
- R7: A snooped bus read on an Exclusive or Dirty line moves it to Shared-2 and asserts `snp_shared`. A Dirty line also asserts `snp_supply` and `snp_wb`.
- R8: A snooped bus read on a Shared-2 line moves it to Shared, and on a Shared line leaves it Shared. Both assert `snp_shared`.
- R9: A snooped bus read on Migratory-Clean or Migratory-Dirty invalidates the line and asserts `snp_migr` but not `snp_shared`. Migratory-Dirty also asserts `snp_supply` and `snp_wb`.
- R10: A snooped read-exclusive invalidates any valid line without `snp_shared`. Dirty and Migratory-Dirty assert `snp_supply` and `snp_wb`. Shared-2 asserts `snp_migr` exactly when its last writer differs from `snp_src`.
- R11: A snoop that finds its line Invalid drives no response and changes nothing.
- R12: A processor access and a snoop to the same line in one cycle: the snoop takes effect, and the access is not done (`proc_done`=0, no bus request). On different lines both take effect in the same cycle.
- R13: `bus_req` is never high unless `proc_done` is high, and a read-exclusive request only comes from a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| proc_valid | input | 1 | Processor access present |
| proc_wr | input | 1 | 1 = write, 0 = read |
| proc_idx | input | IDX_W | Line index of the access; also selects `line_state` |
| resp_shared | input | 1 | Shared response from other caches to this cycle's request |
| resp_migr | input | 1 | Migratory response from other caches to this cycle's request |
| fill_writer | input | ID_W | Last-writer ID that arrives with a read fill |
| snp_valid | input | 1 | Snooped transaction present |
| snp_rdx | input | 1 | 1 = read-exclusive, 0 = bus read |
| snp_idx | input | IDX_W | Line index of the snoop |
| snp_src | input | ID_W | Processor ID of the snooped requester |
| proc_done | output | 1 | Access accepted this cycle |
| bus_req | output | 1 | Bus request for this access |
| bus_cmd | output | 1 | 0 = bus read, 1 = read-exclusive |
| snp_shared | output | 1 | Shared response to the snoop |
| snp_migr | output | 1 | Migratory response to the snoop |
| snp_supply | output | 1 | This cache supplies the data |
| snp_wb | output | 1 | This cache writes the data back |
| line_state | output | 3 | State of line `proc_idx` |

## Verification
A wrong stored state shows at the ports in one of two ways: on the very next cycle through `line_state`, or at the next access to that line as a missing or extra bus request. A wrong state also shows as a wrong response when another processor snoops the line. A bad last-writer field stays hidden until that line reaches Shared-2 and is written or read-exclusively snooped. There it changes the choice between Dirty and Migratory-Dirty, or the value of `snp_migr`. For that reason the tests build the two-copy case from both sides. Same-line collisions are checked in the cycle they occur, through `proc_done` and the response lines.

// File: rtl/mig_coh_pkg.sv
package mig_coh_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_SHR = 3'd1,
        LS_EXC = 3'd2,
        LS_DRT = 3'd3,
        LS_SH2 = 3'd4,
        LS_MCL = 3'd5,
        LS_MDR = 3'd6
    } line_st_e;

    typedef struct packed {
        logic shared;
        logic migr;
        logic supply;
        logic wb;
    } snp_rsp_t;

    typedef struct packed {
        line_st_e nxt;
        logic     req;
        logic     rdx;
    } proc_res_t;

    typedef struct packed {
        line_st_e nxt;
        snp_rsp_t rsp;
    } snp_res_t;

    // Processor-side transition; other_writer: stored last writer is not this cache
    function automatic proc_res_t proc_next(line_st_e cur, logic wr, logic rs,
                                            logic rm, logic other_writer);
        proc_res_t r;
        r.nxt = cur;
        r.req = 1'b0;
        r.rdx = 1'b0;
        if (!wr) begin
            if (cur == LS_INV) begin
                r.req = 1'b1;
                r.nxt = rm ? LS_MCL : (rs ? LS_SHR : LS_EXC);
            end
        end else begin
            case (cur)
                LS_INV: begin r.req = 1'b1; r.rdx = 1'b1; r.nxt = LS_DRT; end
                LS_SHR: begin r.req = 1'b1; r.rdx = 1'b1; r.nxt = rm ? LS_MDR : LS_DRT; end
                LS_SH2: begin r.req = 1'b1; r.rdx = 1'b1; r.nxt = other_writer ? LS_MDR : LS_DRT; end
                LS_EXC: r.nxt = LS_DRT;
                LS_MCL: r.nxt = LS_MDR;
                default: r.nxt = cur;
            endcase
        end
        return r;
    endfunction

    // Snoop-side transition; writer_ne_src: stored last writer differs from requester
    function automatic snp_res_t snoop_next(line_st_e cur, logic rdx, logic writer_ne_src);
        snp_res_t r;
        r.nxt = cur;
        r.rsp = '0;
        if (cur != LS_INV) begin
            if (rdx) begin
                r.nxt = LS_INV;
                if (cur == LS_DRT || cur == LS_MDR) begin
                    r.rsp.supply = 1'b1;
                    r.rsp.wb     = 1'b1;
                end
                if (cur == LS_SH2) r.rsp.migr = writer_ne_src;
            end else begin
                case (cur)
                    LS_SHR: r.rsp.shared = 1'b1;
                    LS_EXC: begin r.nxt = LS_SH2; r.rsp.shared = 1'b1; end
                    LS_DRT: begin
                        r.nxt = LS_SH2;
                        r.rsp.shared = 1'b1;
                        r.rsp.supply = 1'b1;
                        r.rsp.wb     = 1'b1;
                    end
                    LS_SH2: begin r.nxt = LS_SHR; r.rsp.shared = 1'b1; end
                    LS_MCL: begin r.nxt = LS_INV; r.rsp.migr = 1'b1; end
                    LS_MDR: begin
                        r.nxt = LS_INV;
                        r.rsp.migr   = 1'b1;
                        r.rsp.supply = 1'b1;
                        r.rsp.wb     = 1'b1;
                    end
                    default: r.nxt = cur;
                endcase
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mig_line_array.sv
module mig_line_array
    import mig_coh_pkg::*;
#(
    parameter int unsigned NLINES = 8,
    parameter int unsigned ID_W   = 2,
    localparam int unsigned IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             s_we,
    input  logic [IDX_W-1:0] s_idx,
    input  line_st_e         s_st,
    input  logic             p_we,
    input  logic             p_wr_we,
    input  logic [IDX_W-1:0] p_idx,
    input  line_st_e         p_st,
    input  logic [ID_W-1:0]  p_writer,
    output line_st_e         s_cur,
    output logic [ID_W-1:0]  s_writer,
    output line_st_e         p_cur,
    output logic [ID_W-1:0]  p_cur_writer
);
    line_st_e        st_q   [NLINES];
    logic [ID_W-1:0] wrid_q [NLINES];

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[i]   <= LS_INV;
                wrid_q[i] <= '0;
            end else begin
                if (s_we && s_idx == IDX_W'(i))
                    st_q[i] <= s_st;
                else if (p_we && p_idx == IDX_W'(i))
                    st_q[i] <= p_st;
                if (p_wr_we && p_idx == IDX_W'(i))
                    wrid_q[i] <= p_writer;
            end
        end
    end

    always_comb begin
        s_cur        = st_q[s_idx];
        s_writer     = wrid_q[s_idx];
        p_cur        = st_q[p_idx];
        p_cur_writer = wrid_q[p_idx];
    end
endmodule

// File: rtl/mig_proc_path.sv
module mig_proc_path
    import mig_coh_pkg::*;
#(
    parameter int unsigned ID_W  = 2,
    parameter int unsigned MY_ID = 0
) (
    input  logic            go,
    input  logic            wr,
    input  line_st_e        cur,
    input  logic [ID_W-1:0] cur_writer,
    input  logic            rs,
    input  logic            rm,
    input  logic [ID_W-1:0] fill_writer,
    output line_st_e        nxt,
    output logic            req,
    output logic            rdx,
    output logic            st_we,
    output logic            wr_we,
    output logic [ID_W-1:0] new_writer
);
    localparam logic [ID_W-1:0] SELF = ID_W'(MY_ID);
    proc_res_t res;

    always_comb begin
        res        = proc_next(cur, wr, rs, rm, cur_writer != SELF);
        nxt        = res.nxt;
        req        = go && res.req;
        rdx        = go && res.rdx;
        st_we      = go;
        wr_we      = go && (wr || cur == LS_INV);
        new_writer = wr ? SELF : fill_writer;
    end
endmodule

// File: rtl/mig_snoop_path.sv
module mig_snoop_path
    import mig_coh_pkg::*;
#(
    parameter int unsigned ID_W = 2
) (
    input  logic            go,
    input  logic            rdx,
    input  line_st_e        cur,
    input  logic [ID_W-1:0] cur_writer,
    input  logic [ID_W-1:0] src,
    output line_st_e        nxt,
    output snp_rsp_t        rsp,
    output logic            st_we
);
    snp_res_t res;

    always_comb begin
        res   = snoop_next(cur, rdx, cur_writer != src);
        nxt   = res.nxt;
        rsp   = go ? res.rsp : '0;
        st_we = go;
    end
endmodule

// File: rtl/mig_coh_ctrl.sv
module mig_coh_ctrl
    import mig_coh_pkg::*;
#(
    parameter int unsigned NLINES = 8,
    parameter int unsigned ID_W   = 2,
    parameter int unsigned MY_ID  = 0,
    localparam int unsigned IDX_W = (NLINES > 1) ? $clog2(NLINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             proc_valid,
    input  logic             proc_wr,
    input  logic [IDX_W-1:0] proc_idx,
    input  logic             resp_shared,
    input  logic             resp_migr,
    input  logic [ID_W-1:0]  fill_writer,
    input  logic             snp_valid,
    input  logic             snp_rdx,
    input  logic [IDX_W-1:0] snp_idx,
    input  logic [ID_W-1:0]  snp_src,
    output logic             proc_done,
    output logic             bus_req,
    output logic             bus_cmd,
    output logic             snp_shared,
    output logic             snp_migr,
    output logic             snp_supply,
    output logic             snp_wb,
    output logic [2:0]       line_state
);
    line_st_e        s_cur, p_cur, s_nxt, p_nxt;
    logic [ID_W-1:0] s_writer, p_writer, p_new_writer;
    logic            s_we, p_we, p_wr_we;
    snp_rsp_t        rsp;
    logic            collide;

    // Snoop wins a same-line collision; the access is retried by the requester
    assign collide   = proc_valid && snp_valid && (proc_idx == snp_idx);
    assign proc_done = proc_valid && !collide;

    mig_line_array #(.NLINES(NLINES), .ID_W(ID_W)) u_lines (
        .clk(clk), .rst(rst),
        .s_we(s_we), .s_idx(snp_idx), .s_st(s_nxt),
        .p_we(p_we), .p_wr_we(p_wr_we), .p_idx(proc_idx), .p_st(p_nxt),
        .p_writer(p_new_writer),
        .s_cur(s_cur), .s_writer(s_writer),
        .p_cur(p_cur), .p_cur_writer(p_writer)
    );

    mig_proc_path #(.ID_W(ID_W), .MY_ID(MY_ID)) u_proc (
        .go(proc_done), .wr(proc_wr), .cur(p_cur), .cur_writer(p_writer),
        .rs(resp_shared), .rm(resp_migr), .fill_writer(fill_writer),
        .nxt(p_nxt), .req(bus_req), .rdx(bus_cmd),
        .st_we(p_we), .wr_we(p_wr_we), .new_writer(p_new_writer)
    );

    mig_snoop_path #(.ID_W(ID_W)) u_snoop (
        .go(snp_valid), .rdx(snp_rdx), .cur(s_cur), .cur_writer(s_writer),
        .src(snp_src), .nxt(s_nxt), .rsp(rsp), .st_we(s_we)
    );

    assign snp_shared = rsp.shared;
    assign snp_migr   = rsp.migr;
    assign snp_supply = rsp.supply;
    assign snp_wb     = rsp.wb;
    assign line_state = p_cur;
endmodule

// File: rtl/mig_coh_ctrl_chk.sv
module mig_coh_ctrl_chk #(
    parameter int unsigned IDX_W = 3,
    parameter int unsigned ID_W  = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             proc_valid,
    input logic             proc_wr,
    input logic [IDX_W-1:0] proc_idx,
    input logic             snp_valid,
    input logic             snp_rdx,
    input logic [IDX_W-1:0] snp_idx,
    input logic             proc_done,
    input logic             bus_req,
    input logic             bus_cmd,
    input logic             snp_shared,
    input logic             snp_migr,
    input logic             snp_supply,
    input logic             snp_wb,
    input logic [2:0]       line_state
);
    // R13
    req_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
        bus_req |-> proc_done);

    // R13
    rdx_from_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_cmd) |-> proc_wr);

    // R12
    collide_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_valid && snp_valid && proc_idx == snp_idx) |-> !proc_done);

    // R10
    rdx_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_rdx) |=> (proc_idx != $past(snp_idx)) || (line_state == 3'd0));

    // R10
    rdx_not_shared_chk: assert property (@(posedge clk) disable iff (rst)
        (snp_valid && snp_rdx) |-> !snp_shared);

    // R9
    rsp_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(snp_shared && snp_migr));

    // R7
    wb_with_supply_chk: assert property (@(posedge clk) disable iff (rst)
        snp_wb |-> snp_supply);

    // R3
    write_owns_chk: assert property (@(posedge clk) disable iff (rst)
        (proc_done && proc_wr) |=> (proc_idx != $past(proc_idx)) ||
            (line_state == 3'd3) || (line_state == 3'd6));
endmodule

bind mig_coh_ctrl mig_coh_ctrl_chk #(.IDX_W(IDX_W), .ID_W(ID_W)) u_chk (
    .clk(clk), .rst(rst), .proc_valid(proc_valid), .proc_wr(proc_wr),
    .proc_idx(proc_idx), .snp_valid(snp_valid), .snp_rdx(snp_rdx),
    .snp_idx(snp_idx), .proc_done(proc_done), .bus_req(bus_req),
    .bus_cmd(bus_cmd), .snp_shared(snp_shared), .snp_migr(snp_migr),
    .snp_supply(snp_supply), .snp_wb(snp_wb), .line_state(line_state)
);

// File: tb/mig_coh_ctrl_bench.sv
`timescale 1ns/1ps
module mig_coh_ctrl_bench;
    localparam int IDX_W = 3;
    localparam int ID_W  = 2;

    localparam logic [2:0] ST_I = 3'd0, ST_S = 3'd1, ST_E = 3'd2, ST_D = 3'd3,
                           ST_S2 = 3'd4, ST_MC = 3'd5, ST_MD = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic proc_valid = 0, proc_wr = 0, resp_shared = 0, resp_migr = 0;
    logic [IDX_W-1:0] proc_idx = '0, snp_idx = '0;
    logic [ID_W-1:0]  fill_writer = '0, snp_src = '0;
    logic snp_valid = 0, snp_rdx = 0;
    logic proc_done, bus_req, bus_cmd, snp_shared, snp_migr, snp_supply, snp_wb;
    logic [2:0] line_state;

    int n_tests = 0;
    int n_fail  = 0;
    logic c_done, c_req, c_cmd, c_sh, c_mg, c_sup, c_wb;

    always #4 clk = ~clk;

    mig_coh_ctrl #(.NLINES(8), .ID_W(ID_W), .MY_ID(0)) u_mig_coh_ctrl (
        .clk(clk), .rst(rst), .proc_valid(proc_valid), .proc_wr(proc_wr),
        .proc_idx(proc_idx), .resp_shared(resp_shared), .resp_migr(resp_migr),
        .fill_writer(fill_writer), .snp_valid(snp_valid), .snp_rdx(snp_rdx),
        .snp_idx(snp_idx), .snp_src(snp_src), .proc_done(proc_done),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .snp_shared(snp_shared),
        .snp_migr(snp_migr), .snp_supply(snp_supply), .snp_wb(snp_wb),
        .line_state(line_state)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, capture combinational outputs, pass the edge
    task automatic step(input logic pv, input logic pw, input int pi,
                        input logic rs, input logic rm, input int fw,
                        input logic sv, input logic sx, input int si, input int ss);
        proc_valid = pv; proc_wr = pw; proc_idx = IDX_W'(pi);
        resp_shared = rs; resp_migr = rm; fill_writer = ID_W'(fw);
        snp_valid = sv; snp_rdx = sx; snp_idx = IDX_W'(si); snp_src = ID_W'(ss);
        #1;
        c_done = proc_done; c_req = bus_req; c_cmd = bus_cmd;
        c_sh = snp_shared; c_mg = snp_migr; c_sup = snp_supply; c_wb = snp_wb;
        @(negedge clk);
        proc_valid = 0; snp_valid = 0; resp_shared = 0; resp_migr = 0;
    endtask

    task automatic pop(input int idx, input logic wr, input logic rs, input logic rm, input int fw);
        step(1, wr, idx, rs, rm, fw, 0, 0, 0, 0);
    endtask

    task automatic snp(input int idx, input logic rdx, input int src);
        step(0, 0, 0, 0, 0, 0, 1, rdx, idx, src);
    endtask

    task automatic st_is(input string tag, input int idx, input logic [2:0] exp);
        proc_idx = IDX_W'(idx);
        #1;
        chk(tag, line_state, exp);
    endtask

    task automatic rsp_is(input string tag, input logic sh, input logic mg,
                          input logic sup, input logic wb);
        chk({tag, " shared"}, c_sh, sh);
        chk({tag, " migr"}, c_mg, mg);
        chk({tag, " supply"}, c_sup, sup);
        chk({tag, " wb"}, c_wb, wb);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) st_is("R1 reset state", i, ST_I);
    endtask

    task automatic t_read_fill();
        pop(0, 0, 0, 0, 2);
        chk("R2 miss req", c_req, 1); chk("R2 miss cmd", c_cmd, 0);
        st_is("R2 fill E", 0, ST_E);
        pop(1, 0, 1, 0, 2); st_is("R2 fill S", 1, ST_S);
        pop(2, 0, 1, 1, 2); st_is("R2 fill MC", 2, ST_MC);
        pop(0, 0, 0, 0, 0);
        chk("R2 hit no req", c_req, 0); chk("R2 hit done", c_done, 1);
        st_is("R2 hit keeps E", 0, ST_E);
    endtask

    task automatic t_write_hit();
        pop(0, 1, 0, 0, 0); chk("R3 E write no req", c_req, 0); st_is("R3 E->D", 0, ST_D);
        pop(2, 1, 0, 0, 0); chk("R3 MC write no req", c_req, 0); st_is("R3 MC->MD", 2, ST_MD);
        pop(0, 1, 0, 0, 0); chk("R3 D write no req", c_req, 0); st_is("R3 D stays", 0, ST_D);
    endtask

    task automatic t_write_miss();
        pop(3, 1, 1, 1, 0);
        chk("R4 req", c_req, 1); chk("R4 cmd rdx", c_cmd, 1);
        st_is("R4 I->D", 3, ST_D);
    endtask

    task automatic t_write_shared();
        pop(1, 1, 0, 1, 0);
        chk("R5 req", c_req, 1); chk("R5 cmd", c_cmd, 1);
        st_is("R5 S->MD migr", 1, ST_MD);
        pop(4, 0, 1, 0, 0); pop(4, 1, 0, 0, 0);
        st_is("R5 S->D plain", 4, ST_D);
    endtask

    task automatic t_shared2_write();
        pop(5, 0, 0, 0, 2);
        snp(5, 0, 3); rsp_is("R7 E rd", 1, 0, 0, 0);
        st_is("R7 E->S2", 5, ST_S2);
        pop(5, 1, 0, 0, 0);
        chk("R6 req", c_req, 1); chk("R6 cmd", c_cmd, 1);
        st_is("R6 S2 other writer->MD", 5, ST_MD);
        pop(6, 1, 0, 0, 0);
        snp(6, 0, 3); rsp_is("R7 D rd", 1, 0, 1, 1);
        st_is("R7 D->S2", 6, ST_S2);
        pop(6, 1, 0, 0, 0);
        st_is("R6 S2 self writer->D", 6, ST_D);
    endtask

    task automatic t_snoop_read();
        pop(7, 0, 0, 0, 1); snp(7, 0, 2); snp(7, 0, 3);
        rsp_is("R8 S2 rd", 1, 0, 0, 0); st_is("R8 S2->S", 7, ST_S);
        snp(7, 0, 2); rsp_is("R8 S rd", 1, 0, 0, 0); st_is("R8 S stays", 7, ST_S);
        snp(2, 0, 3); rsp_is("R9 MD rd", 0, 1, 1, 1); st_is("R9 MD->I", 2, ST_I);
        pop(2, 0, 0, 1, 3); st_is("R2 refill MC", 2, ST_MC);
        snp(2, 0, 1); rsp_is("R9 MC rd", 0, 1, 0, 0); st_is("R9 MC->I", 2, ST_I);
    endtask

    task automatic t_snoop_rdx();
        snp(0, 1, 2); rsp_is("R10 D rdx", 0, 0, 1, 1); st_is("R10 D->I", 0, ST_I);
        snp(4, 0, 2); snp(4, 1, 2); rsp_is("R10 S2 rdx other", 0, 1, 0, 0);
        st_is("R10 S2->I", 4, ST_I);
        snp(3, 0, 2); snp(3, 1, 0); rsp_is("R10 S2 rdx same writer", 0, 0, 0, 0);
        snp(7, 1, 2); rsp_is("R10 S rdx", 0, 0, 0, 0); st_is("R10 S->I", 7, ST_I);
    endtask

    task automatic t_invalid_snoop();
        snp(0, 0, 2); rsp_is("R11 I rd", 0, 0, 0, 0); st_is("R11 I stays", 0, ST_I);
        snp(0, 1, 2); rsp_is("R11 I rdx", 0, 0, 0, 0); st_is("R11 I stays rdx", 0, ST_I);
    endtask

    task automatic t_collide();
        step(1, 1, 1, 0, 0, 0, 1, 0, 1, 2);
        chk("R12 same line not done", c_done, 0); chk("R12 same line no req", c_req, 0);
        rsp_is("R12 snoop applied", 0, 1, 1, 1);
        st_is("R12 MD->I by snoop", 1, ST_I);
        step(1, 0, 0, 0, 0, 0, 1, 0, 5, 2);
        chk("R12 diff line done", c_done, 1); chk("R12 diff line req", c_req, 1);
        chk("R12 diff line migr", c_mg, 1);
        st_is("R12 proc line E", 0, ST_E);
        st_is("R12 snoop line I", 5, ST_I);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_fill();
        t_write_hit();
        t_write_miss();
        t_write_shared();
        t_shared2_write();
        t_snoop_read();
        t_snoop_rdx();
        t_invalid_snoop();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule